// File: doc/BRIEF.md
# Voice Channel Codec Control and PCM Loopback

This block is the digital control part of one voice filter/codec channel. Software, or a line card sequencer, sends 8-bit control words over a serial control line, most significant bit first. When the word frame closes, a complete word goes into one of two control registers. The register-select input picks which one. The upper two bits of the primary register choose the channel function. The upper two bits of the secondary register choose a test state.

The PCM side runs in an 8-bit-time channel slot. The received serial byte is gathered, most significant bit first, and handed to a parallel decoder sample port. The byte sent in the next slot is chosen by the function. Normal operation sends the external encoder's result. Digital loopback forces the decoder port to zero and sends back the received byte. Analog loopback decodes as normal, mutes the receive analog output, and feeds the decoded sample through the encoder path back onto the transmit line. The companding is modelled as an identity here. Powerdown releases the transmit line, zeroes the decoder port and mutes the output.

After reset, a fixed hold-off window keeps the channel in powerdown. Control words that close inside that window are thrown away.

Top module: `pcm_codec_ctrl`

## Requirements
- R1: A control word is taken in on `ctl_d_i`, one bit for each clock while `ctl_en_i` is high, with bit 7 first. The word closes on the first clock with `ctl_en_i` low. If exactly 8 bits arrived and `reg_sel_i` is low at the close, the primary register is loaded. From the next cycle `mode_o` then equals word bits 7:6. The encodings are 00 normal, 01 digital loopback, 10 analog loopback and 11 powerdown.
- R2: If `reg_sel_i` is high at the close of an 8-bit word, the secondary register is loaded. `test_o` then equals word bits 7:6, and `mode_o` is left unchanged. `test_o` is 00 after reset.
- R3: A control word of any length other than 8 bits loads neither register.
- R4: During reset and for 25 clocks after it, `mode_o` reads 11. Any control word that closes in that window is discarded and is not applied later.
- R5: In normal mode, the 8 bits on `pcm_rx_i` in one slot, MSB first, appear on `dec_data_o`, with `dec_valid_o` high, in the cycle after the 8th slot clock. The next slot sends `enc_data_i` MSB first, where `enc_data_i` is sampled while `slot_i` is low.
- R6: In digital loopback, `dec_data_o` is 00 when `dec_valid_o` is high. The next slot sends the byte received in the previous slot.
- R7: In analog loopback, `dec_data_o` carries the received byte, `rx_mute_o` is high, and the next slot sends the received byte.
- R8: In powerdown, `pcm_tx_oe_o` stays low, `dec_valid_o` stays low, `dec_data_o` is 00 and `rx_mute_o` is high.
- R9: `pcm_tx_oe_o` is high only while `slot_i` is high.
- R10: `rx_mute_o` is low in normal mode and in digital loopback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| ctl_en_i | input | 1 | Control word frame, high while bits shift in |
| ctl_d_i | input | 1 | Serial control data, MSB first |
| reg_sel_i | input | 1 | Register select at word close: 0 primary, 1 secondary |
| slot_i | input | 1 | High during the 8 bit times of the channel slot |
| pcm_rx_i | input | 1 | Serial PCM receive data, MSB first |
| pcm_tx_o | output | 1 | Serial PCM transmit data |
| pcm_tx_oe_o | output | 1 | Transmit drive enable; low means high impedance |
| enc_data_i | input | 8 | Parallel sample from the encoder |
| dec_data_o | output | 8 | Parallel sample to the decoder |
| dec_valid_o | output | 1 | One-cycle strobe for a new decoder sample |
| rx_mute_o | output | 1 | Receive analog output muted |
| mode_o | output | 2 | Channel function in effect |
| test_o | output | 2 | Test state from the secondary register |

## Verification
Some rules are checked by assertions on every cycle. The transmit enable never rises outside the slot or in powerdown, and powerdown always mutes the output. Neither register changes without a complete, accepted word, and neither changes while the hold-off is running. A digital-loopback decoder strobe always carries zero, and in that mode the first transmitted bit of a slot comes from the received byte. Other behaviour only the bench scenarios can show. These are the end-to-end routing of bytes between the receive line, the decoder port, the encoder port and the transmit line in each mode. The bench also covers the MSB-first bit order, the rejection of partial words, and a write inside the hold-off window that is dropped and never applied later.

// File: rtl/pcm_ctrl_pkg.sv
package pcm_ctrl_pkg;

  typedef enum logic [1:0] {
    FN_NORMAL = 2'b00,
    FN_DIG_LB = 2'b01,
    FN_ANA_LB = 2'b10,
    FN_PWRDN  = 2'b11
  } fn_mode_e;

  // Sample presented to the decoder port for a received byte.
  function automatic logic [7:0] dec_drive(fn_mode_e m, logic [7:0] rx_byte);
    if (m == FN_NORMAL || m == FN_ANA_LB) return rx_byte;
    return 8'h00;
  endfunction

  // Byte queued for the next transmit slot. Analog loopback re-encodes the
  // decoded sample; the companding is modelled as identity.
  function automatic logic [7:0] tx_pick(fn_mode_e m, logic [7:0] rx_byte,
                                         logic [7:0] enc_byte);
    if (m == FN_NORMAL) return enc_byte;
    return rx_byte;
  endfunction

  function automatic logic mute_of(fn_mode_e m);
    return (m == FN_ANA_LB) || (m == FN_PWRDN);
  endfunction

endpackage

// File: rtl/pcm_holdoff.sv
module pcm_holdoff #(
  parameter int HOLD_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == LIMIT);

  // R4
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);

endmodule

// File: rtl/pcm_ctl_rx.sv
module pcm_ctl_rx #(
  parameter int          W     = 8,
  parameter logic [1:0]  A_RST = 2'b11,
  parameter logic [1:0]  B_RST = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready_i,
  input  logic       ctl_en_i,
  input  logic       ctl_d_i,
  input  logic       reg_sel_i,
  output logic [1:0] fn_a_o,
  output logic [1:0] fn_b_o,
  output logic       load_a_o,
  output logic       load_b_o
);
  localparam int CW = $clog2(W + 2);
  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [CW-1:0] OVER = CW'(W + 1);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;
  logic          word_close;
  logic          word_ok;

  assign word_close = !ctl_en_i && (cnt_q != '0);
  assign word_ok    = word_close && (cnt_q == FULL) && ready_i;
  assign load_a_o   = word_ok && !reg_sel_i;
  assign load_b_o   = word_ok && reg_sel_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (ctl_en_i) begin
      sr_q <= {sr_q[W-2:0], ctl_d_i};
      if (cnt_q != OVER) cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_a_o <= A_RST;
      fn_b_o <= B_RST;
    end else begin
      if (load_a_o) fn_a_o <= sr_q[W-1:W-2];
      if (load_b_o) fn_b_o <= sr_q[W-1:W-2];
    end
  end

  // R4
  lock_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> $stable(fn_a_o) && $stable(fn_b_o));

  // R3
  a_load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_a_o |=> $stable(fn_a_o));

  // R2
  b_load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_b_o |=> $stable(fn_b_o));

endmodule

// File: rtl/pcm_path.sv
module pcm_path
  import pcm_ctrl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  fn_mode_e     mode_i,
  input  logic         slot_i,
  input  logic         rx_i,
  input  logic [W-1:0] enc_i,
  output logic         tx_o,
  output logic         tx_oe_o,
  output logic [W-1:0] dec_o,
  output logic         dec_vld_o,
  output logic         mute_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-2:0]  rx_sr_q;
  logic [CW-1:0] rx_cnt_q;
  logic [W-1:0]  rx_byte_q;
  logic [W-1:0]  rx_next;
  logic [W-1:0]  tx_sr_q;
  logic          byte_done;
  logic          pd;

  assign pd        = (mode_i == FN_PWRDN);
  assign rx_next   = {rx_sr_q, rx_i};
  assign byte_done = slot_i && (rx_cnt_q == LAST);

  // Receive shift and byte latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr_q   <= '0;
      rx_cnt_q  <= '0;
      rx_byte_q <= '0;
    end else if (slot_i) begin
      rx_sr_q <= rx_next[W-2:0];
      if (byte_done) begin
        rx_byte_q <= rx_next;
        rx_cnt_q  <= '0;
      end else begin
        rx_cnt_q <= rx_cnt_q + 1'b1;
      end
    end else begin
      rx_cnt_q <= '0;
    end
  end

  // Decoder port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_o     <= '0;
      dec_vld_o <= 1'b0;
    end else if (pd) begin
      dec_o     <= '0;
      dec_vld_o <= 1'b0;
    end else begin
      dec_vld_o <= byte_done;
      if (byte_done) dec_o <= dec_drive(mode_i, rx_next);
    end
  end

  // Transmit register: preloaded between slots, shifted during the slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_sr_q <= '0;
    else if (!slot_i) tx_sr_q <= tx_pick(mode_i, rx_byte_q, enc_i);
    else tx_sr_q <= {tx_sr_q[W-2:0], 1'b0};
  end

  assign tx_o    = tx_sr_q[W-1];
  assign tx_oe_o = slot_i && !pd;
  assign mute_o  = mute_of(mode_i);

  // R5
  dec_strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_o |-> $past(byte_done));

  // R6
  dlb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld_o && $past(mode_i) == FN_DIG_LB) |-> (dec_o == '0));

  // R6
  dlb_tx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && !$past(slot_i) && mode_i == FN_DIG_LB && $past(mode_i) == FN_DIG_LB)
      |-> (tx_o == rx_byte_q[W-1]));

endmodule

// File: rtl/pcm_codec_ctrl.sv
module pcm_codec_ctrl
  import pcm_ctrl_pkg::*;
#(
  parameter int W        = 8,
  parameter int HOLD_CYC = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_en_i,
  input  logic         ctl_d_i,
  input  logic         reg_sel_i,
  input  logic         slot_i,
  input  logic         pcm_rx_i,
  output logic         pcm_tx_o,
  output logic         pcm_tx_oe_o,
  input  logic [W-1:0] enc_data_i,
  output logic [W-1:0] dec_data_o,
  output logic         dec_valid_o,
  output logic         rx_mute_o,
  output logic [1:0]   mode_o,
  output logic [1:0]   test_o
);
  logic       ready;
  logic [1:0] fn_a;
  logic [1:0] fn_b;
  logic       load_a;
  logic       load_b;
  fn_mode_e   mode_eff;

  pcm_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready_o (ready)
  );

  pcm_ctl_rx #(.W(W), .A_RST(2'b11), .B_RST(2'b00)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready_i   (ready),
    .ctl_en_i  (ctl_en_i),
    .ctl_d_i   (ctl_d_i),
    .reg_sel_i (reg_sel_i),
    .fn_a_o    (fn_a),
    .fn_b_o    (fn_b),
    .load_a_o  (load_a),
    .load_b_o  (load_b)
  );

  assign mode_eff = ready ? fn_mode_e'(fn_a) : FN_PWRDN;
  assign mode_o   = mode_eff;
  assign test_o   = fn_b;

  pcm_path #(.W(W)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_eff),
    .slot_i    (slot_i),
    .rx_i      (pcm_rx_i),
    .enc_i     (enc_data_i),
    .tx_o      (pcm_tx_o),
    .tx_oe_o   (pcm_tx_oe_o),
    .dec_o     (dec_data_o),
    .dec_vld_o (dec_valid_o),
    .mute_o    (rx_mute_o)
  );

  // R9
  oe_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_tx_oe_o |-> slot_i);

  // R8
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11) |-> (rx_mute_o && !pcm_tx_oe_o));

  // R1
  load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_a && load_b));

endmodule

// File: tb/tb_pcm_codec_ctrl.sv
`timescale 1ns/100ps
module tb_pcm_codec_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_en_i = 1'b0, ctl_d_i = 1'b0, reg_sel_i = 1'b0;
  logic       slot_i = 1'b0, pcm_rx_i = 1'b0;
  logic [7:0] enc_data_i = 8'h00;
  logic       pcm_tx_o, pcm_tx_oe_o, dec_valid_o, rx_mute_o;
  logic [7:0] dec_data_o;
  logic [1:0] mode_o, test_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pcm_codec_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ctl_en_i(ctl_en_i), .ctl_d_i(ctl_d_i),
    .reg_sel_i(reg_sel_i), .slot_i(slot_i), .pcm_rx_i(pcm_rx_i),
    .pcm_tx_o(pcm_tx_o), .pcm_tx_oe_o(pcm_tx_oe_o), .enc_data_i(enc_data_i),
    .dec_data_o(dec_data_o), .dec_valid_o(dec_valid_o), .rx_mute_o(rx_mute_o),
    .mode_o(mode_o), .test_o(test_o)
  );

  // {mode, rx byte, enc byte, expected dec, expected tx, expected mute}
  localparam logic [34:0] VEC [7] = '{
    {2'b00, 8'hA5, 8'h3C, 8'hA5, 8'h3C, 1'b0},
    {2'b00, 8'h01, 8'h80, 8'h01, 8'h80, 1'b0},
    {2'b01, 8'h96, 8'h3C, 8'h00, 8'h96, 1'b0},
    {2'b01, 8'h7F, 8'h11, 8'h00, 8'h7F, 1'b0},
    {2'b10, 8'hC3, 8'h55, 8'hC3, 8'hC3, 1'b1},
    {2'b10, 8'h08, 8'hFF, 8'h08, 8'h08, 1'b1},
    {2'b11, 8'h5A, 8'h22, 8'h00, 8'h00, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic sel, input logic [7:0] val, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ctl_en_i = 1'b1; ctl_d_i = val[7-(i%8)]; reg_sel_i = sel;
    end
    @(negedge clk);
    ctl_en_i = 1'b0;
    @(negedge clk);
    #1;
  endtask

  task automatic run_slot(input logic [7:0] rx, output logic [7:0] tx,
                          output int oe_n, output logic [7:0] dec,
                          output logic vld, output logic oe_gap);
    repeat (2) @(negedge clk);
    oe_n = 0;
    tx = 8'h00;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      slot_i = 1'b1; pcm_rx_i = rx[7-k];
      #1;
      tx[7-k] = pcm_tx_o;
      if (pcm_tx_oe_o) oe_n++;
    end
    @(negedge clk);
    slot_i = 1'b0;
    #1;
    dec = dec_data_o; vld = dec_valid_o; oe_gap = pcm_tx_oe_o;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] tx, dec;
    logic       vld, oe_gap;
    int         oe_n;

    repeat (3) @(negedge clk);
    #1;
    check(mode_o == 2'b11, "R4 reset mode", mode_o, 2'b11);
    check(!pcm_tx_oe_o, "R8 reset oe", pcm_tx_oe_o, 0);
    check(dec_data_o == 8'h00 && rx_mute_o, "R8 reset dec/mute", {dec_data_o, rx_mute_o}, 9'h001);
    check(test_o == 2'b00, "R2 reset test", test_o, 0);

    @(negedge clk);
    rst_n = 1'b1;
    // Write closes well inside the hold-off window: must be discarded
    write_ctl(1'b0, 8'h00, 8);
    check(mode_o == 2'b11, "R4 write during hold-off", mode_o, 2'b11);
    repeat (25) @(negedge clk);
    #1;
    check(mode_o == 2'b11, "R4 no deferred write", mode_o, 2'b11);

    write_ctl(1'b0, 8'h40, 8);
    check(mode_o == 2'b01, "R1 load primary", mode_o, 2'b01);
    write_ctl(1'b1, 8'h80, 8);
    check(test_o == 2'b10, "R2 load secondary test", test_o, 2'b10);
    check(mode_o == 2'b01, "R2 primary unchanged", mode_o, 2'b01);
    write_ctl(1'b0, 8'hC0, 5);
    check(mode_o == 2'b01, "R3 short word", mode_o, 2'b01);
    write_ctl(1'b0, 8'h80, 9);
    check(mode_o == 2'b01, "R3 long word", mode_o, 2'b01);

    foreach (VEC[i]) begin
      logic [1:0] m;
      logic [7:0] rx, enc, edec, etx;
      logic       emute;
      {m, rx, enc, edec, etx, emute} = VEC[i];
      write_ctl(1'b0, {m, 6'b000000}, 8);
      check(mode_o == m, "R1 mode field", mode_o, m);
      enc_data_i = enc;
      run_slot(rx, tx, oe_n, dec, vld, oe_gap);
      check(rx_mute_o == emute, emute ? "R7 mute" : "R10 mute", rx_mute_o, emute);
      check(!oe_gap, "R9 oe outside slot", oe_gap, 0);
      if (m == 2'b11) begin
        check(!vld && dec == 8'h00, "R8 decoder quiet", {vld, dec}, 0);
        run_slot(8'h00, tx, oe_n, dec, vld, oe_gap);
        check(oe_n == 0, "R8 transmit released", oe_n, 0);
      end else begin
        check(vld && dec == edec,
              m == 2'b00 ? "R5 decoder sample" : (m == 2'b01 ? "R6 decoder zero" : "R7 decoder sample"),
              {vld, dec}, {1'b1, edec});
        run_slot(8'h00, tx, oe_n, dec, vld, oe_gap);
        check(oe_n == 8, "R9 oe over slot", oe_n, 8);
        check(tx == etx,
              m == 2'b00 ? "R5 transmit byte" : (m == 2'b01 ? "R6 transmit byte" : "R7 transmit byte"),
              tx, etx);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule